// File: doc/BRIEF.md
# Watchdog Period Control Register with Write Unlock

This block holds the one-byte control register of a supervisor's watchdog. The register carries a two-bit watchdog period code that is meant to survive power loss, plus two volatile enable latches: a write-enable latch and a register-write-enable latch. A serial bus front end decodes transactions addressed to the register. It hands the block one request per transaction, either a single written byte or a read. One cycle later the block answers with a response strobe, an acknowledge flag and, for reads, the register image.

The period code can only change after a three-step unlock. The first write sets the write-enable latch. The second sets the register-write-enable latch as well. The third carries the new period code and starts the persistent commit. The commit is modelled as a busy interval counted in millisecond ticks. During that interval every request is refused, and the new code reaches the watchdog when the interval ends. A write-protect input blocks all register writes. An active supervisor reset abandons a commit in progress.

Top module: `wdt_ctrl_reg`

## Requirements
- R1: The register image is {0, P[1], P[0], 0, 0, RW, W, 0}, with bit 7 first. P is the period code, RW is the register-write-enable latch and W is the write-enable latch. A read that is not refused is acknowledged and returns this image. A refused read returns 00h.
- R2: After reset, W and RW are 0, busy_o is 0 and the period code equals WD_INIT (default 2'b11).
- R3: While W is 0, a write of any value other than 02h is not acknowledged and changes nothing.
- R4: Writing 02h sets W and writing 06h sets both RW and W. Both writes are acknowledged, neither raises busy_o, and the next request is accepted.
- R5: While RW is 1, a written value matching 0xy0_0010 is acknowledged, clears RW and raises busy_o in the next cycle. busy_o stays high until WR_MS tick_i pulses have been seen. At the edge that takes the last tick, busy_o falls and the period code becomes xy.
- R6: While RW is 1, a written value matching 0xy0_0110 is acknowledged and leaves the period code, RW and W unchanged.
- R7: While wp_i is 1, a write is not acknowledged, leaves W and the period code unchanged and clears RW.
- R8: A read between the unlock steps leaves W and RW unchanged, so the sequence can still complete.
- R9: While W is 1, writing 00h is acknowledged and clears W.
- R10: While busy_o is 1, reads and writes are not acknowledged and change nothing.
- R11: While sup_rst_i is 1, any commit in progress is dropped. busy_o is 0 from the next cycle and the period code keeps its old value. Requests made while sup_rst_i is 1 are not acknowledged.
- R12: While W is 1, any other written value is acknowledged and leaves the register unchanged.
- R13: Every read or write request yields exactly one rsp_valid_o pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| wp_i | input | 1 | Write protect, high blocks register writes |
| sup_rst_i | input | 1 | Supervisor reset active, aborts commit |
| wr_req_i | input | 1 | Write request strobe from the bus front end |
| rd_req_i | input | 1 | Read request strobe from the bus front end |
| wr_data_i | input | 8 | Byte written with wr_req_i |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_ack_o | output | 1 | Front end should acknowledge the byte |
| rd_data_o | output | 8 | Register image for an accepted read |
| busy_o | output | 1 | Persistent commit in progress |
| wd_period_o | output | 2 | Period code driven to the watchdog |

## Verification
A wrong latch state surfaces at the very next request. The acknowledge flag of the following write, and the image returned by a read one cycle after its request, both expose W and RW. Errors in the commit path show as a busy interval that is one tick too short or too long, or as a period code that moves before busy_o falls. The bench counts ticks precisely around the last one to catch this. An abort that fails is visible as busy_o still high, or the code still updating, in the cycle after sup_rst_i.

// File: rtl/wdreg_pkg.sv
package wdreg_pkg;
  localparam logic [7:0] VAL_SET_WEL  = 8'h02;
  localparam logic [7:0] VAL_SET_RWEL = 8'h06;
  localparam logic [7:0] VAL_CLR_WEL  = 8'h00;
  localparam logic [7:0] PAT_MASK     = 8'h9F;
  localparam int unsigned POS_WEL  = 1;
  localparam int unsigned POS_RWEL = 2;
  localparam int unsigned POS_WD0  = 5;
  localparam int unsigned POS_WD1  = 6;

  typedef enum logic [2:0] {
    OP_REFUSE,
    OP_WP,
    OP_SET_WEL,
    OP_SET_RWEL,
    OP_CLR_WEL,
    OP_COMMIT,
    OP_KEEP
  } wr_op_e;
endpackage

// File: rtl/wdreg_decode.sv
module wdreg_decode
  import wdreg_pkg::*;
(
  input  logic [7:0] data_i,
  input  logic       wel_i,
  input  logic       rwel_i,
  input  logic       wp_i,
  input  logic       blocked_i,
  output wr_op_e     op_o,
  output logic       ack_o
);
  logic is_commit_pat, is_keep_pat;

  always_comb begin
    is_commit_pat = (data_i & PAT_MASK) == VAL_SET_WEL;
    is_keep_pat   = (data_i & PAT_MASK) == VAL_SET_RWEL;
    op_o  = OP_REFUSE;
    ack_o = 1'b0;
    if (blocked_i) begin
      op_o = OP_REFUSE;
    end else if (wp_i) begin
      op_o = OP_WP;
    end else if (!wel_i) begin
      if (data_i == VAL_SET_WEL) begin
        op_o  = OP_SET_WEL;
        ack_o = 1'b1;
      end
    end else begin
      ack_o = 1'b1;
      if (data_i == VAL_CLR_WEL)        op_o = OP_CLR_WEL;
      else if (rwel_i && is_commit_pat) op_o = OP_COMMIT;
      else if (rwel_i && is_keep_pat)   op_o = OP_KEEP;
      else if (data_i == VAL_SET_WEL)   op_o = OP_SET_WEL;
      else if (data_i == VAL_SET_RWEL)  op_o = OP_SET_RWEL;
      else                              op_o = OP_KEEP;
    end
  end
endmodule

// File: rtl/wdreg_commit.sv
module wdreg_commit #(
  parameter int unsigned WR_MS   = 10,
  parameter logic [1:0]  WD_INIT = 2'b11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       abort_i,
  input  logic       start_i,
  input  logic [1:0] code_i,
  output logic       busy_o,
  output logic [1:0] code_o
);
  localparam int unsigned CW = $clog2(WR_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(WR_MS - 1);

  logic [CW-1:0] cnt_q;
  logic [1:0]    stage_q, code_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= WD_INIT;
      code_q  <= WD_INIT;
      busy_q  <= 1'b0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      stage_q <= code_i;
    end else if (busy_q && tick_i) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        code_q <= stage_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign code_o = code_q;
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdreg_pkg::*;
#(
  parameter int unsigned WR_MS   = 10,
  parameter logic [1:0]  WD_INIT = 2'b11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wp_i,
  input  logic       sup_rst_i,
  input  logic       wr_req_i,
  input  logic       rd_req_i,
  input  logic [7:0] wr_data_i,
  output logic       rsp_valid_o,
  output logic       rsp_ack_o,
  output logic [7:0] rd_data_o,
  output logic       busy_o,
  output logic [1:0] wd_period_o
);
  logic       wel_q, rwel_q;
  logic       blocked;
  wr_op_e     op;
  logic       wr_ack;
  logic       commit_start;
  logic [1:0] period;
  logic [7:0] image;

  assign blocked = busy_o | sup_rst_i;

  wdreg_decode u_dec (
    .data_i   (wr_data_i),
    .wel_i    (wel_q),
    .rwel_i   (rwel_q),
    .wp_i     (wp_i),
    .blocked_i(blocked),
    .op_o     (op),
    .ack_o    (wr_ack)
  );

  assign commit_start = wr_req_i && (op == OP_COMMIT);

  wdreg_commit #(.WR_MS(WR_MS), .WD_INIT(WD_INIT)) u_cmt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .abort_i(sup_rst_i),
    .start_i(commit_start),
    .code_i ({wr_data_i[POS_WD1], wr_data_i[POS_WD0]}),
    .busy_o (busy_o),
    .code_o (period)
  );

  always_comb begin
    image = '0;
    image[POS_WD1]  = period[1];
    image[POS_WD0]  = period[0];
    image[POS_RWEL] = rwel_q;
    image[POS_WEL]  = wel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (wr_req_i) begin
      unique case (op)
        OP_WP:       rwel_q <= 1'b0;
        OP_SET_WEL:  wel_q  <= 1'b1;
        OP_SET_RWEL: begin wel_q <= 1'b1; rwel_q <= 1'b1; end
        OP_CLR_WEL:  wel_q  <= 1'b0;
        OP_COMMIT:   rwel_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ack_o   <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      rsp_valid_o <= wr_req_i | rd_req_i;
      rd_data_o   <= '0;
      if (wr_req_i) begin
        rsp_ack_o <= wr_ack;
      end else if (rd_req_i) begin
        rsp_ack_o <= !blocked;
        if (!blocked) rd_data_o <= image;
      end else begin
        rsp_ack_o <= 1'b0;
      end
    end
  end

  assign wd_period_o = period;
endmodule

// File: rtl/wdreg_checker.sv
module wdreg_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_req_i,
  input logic       rd_req_i,
  input logic [7:0] wr_data_i,
  input logic       wp_i,
  input logic       sup_rst_i,
  input logic       busy_o,
  input logic [1:0] wd_period_o,
  input logic       rsp_valid_o,
  input logic       rsp_ack_o,
  input logic [7:0] rd_data_o,
  input logic       wel_q,
  input logic       rwel_q
);
  a_r1_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rd_data_o & 8'h99) == 8'h00);
  a_r3_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !wel_q && wr_data_i != 8'h02) |=> !rsp_ack_o);
  a_r5_code_moves_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wd_period_o) |-> $fell(busy_o));
  a_r5_rwel_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !rwel_q);
  a_r7_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && wp_i) |=> (!rsp_ack_o && !rwel_q));
  a_r10_busy_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_req_i || rd_req_i) && busy_o) |=> !rsp_ack_o);
  a_r11_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_rst_i |=> !busy_o);
  a_r13_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i || rd_req_i) |=> rsp_valid_o);
endmodule

bind wdt_ctrl_reg wdreg_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_req_i   (wr_req_i),
  .rd_req_i   (rd_req_i),
  .wr_data_i  (wr_data_i),
  .wp_i       (wp_i),
  .sup_rst_i  (sup_rst_i),
  .busy_o     (busy_o),
  .wd_period_o(wd_period_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ack_o  (rsp_ack_o),
  .rd_data_o  (rd_data_o),
  .wel_q      (wel_q),
  .rwel_q     (rwel_q)
);

// File: tb/wdt_ctrl_reg_bench.sv
module wdt_ctrl_reg_bench;
  localparam int unsigned WR_MS = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, wp_i = 1'b0, sup_rst_i = 1'b0;
  logic       wr_req_i = 1'b0, rd_req_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rsp_valid_o, rsp_ack_o, busy_o;
  logic [7:0] rd_data_o;
  logic [1:0] wd_period_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit         is_rd;
    bit         ack;
    logic [7:0] data;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  wdt_ctrl_reg #(.WR_MS(WR_MS), .WD_INIT(2'b11)) u_wdt_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wp_i(wp_i),
    .sup_rst_i(sup_rst_i), .wr_req_i(wr_req_i), .rd_req_i(rd_req_i),
    .wr_data_i(wr_data_i), .rsp_valid_o(rsp_valid_o), .rsp_ack_o(rsp_ack_o),
    .rd_data_o(rd_data_o), .busy_o(busy_o), .wd_period_o(wd_period_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R13 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_ack_o == e.ack, e.tag, int'(rsp_ack_o), int'(e.ack));
        if (e.is_rd)
          check(rd_data_o == e.data, e.tag, int'(rd_data_o), int'(e.data));
      end
    end
  end

  task automatic issue(input bit is_rd, input logic [7:0] d, input bit ack,
                       input logic [7:0] exp_d, input string tag);
    exp_t e;
    @(negedge clk);
    rd_req_i  = is_rd;
    wr_req_i  = !is_rd;
    wr_data_i = d;
    e.is_rd = is_rd; e.ack = ack; e.data = exp_d; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    rd_req_i = 1'b0;
    wr_req_i = 1'b0;
    check(rsp_valid_o == 1'b1, "R13 response strobe", int'(rsp_valid_o), 1);
  endtask

  task automatic wr(input logic [7:0] d, input bit ack, input string tag);
    issue(1'b0, d, ack, 8'h00, tag);
  endtask

  task automatic rd(input bit ack, input logic [7:0] exp_d, input string tag);
    issue(1'b1, 8'h00, ack, exp_d, tag);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(wd_period_o == 2'b11, "R2 reset period", int'(wd_period_o), 3);
    check(busy_o == 1'b0, "R2 reset busy", int'(busy_o), 0);
    rd(1'b1, 8'h60, "R2 R1 reset image");

    wr(8'h06, 1'b0, "R3 locked write no ack");
    wr(8'h42, 1'b0, "R3 locked write no ack");
    rd(1'b1, 8'h60, "R3 unchanged");

    wr(8'h02, 1'b1, "R4 set wel");
    check(busy_o == 1'b0, "R4 no busy", int'(busy_o), 0);
    rd(1'b1, 8'h62, "R4 wel image");
    wr(8'h55, 1'b1, "R12 other value ack");
    rd(1'b1, 8'h62, "R12 unchanged");
    wr(8'h06, 1'b1, "R4 set rwel");
    rd(1'b1, 8'h66, "R4 R8 rwel image");
    wr(8'h26, 1'b1, "R6 keep pattern ack");
    rd(1'b1, 8'h66, "R6 unchanged");

    wr(8'h22, 1'b1, "R5 commit ack");
    check(busy_o == 1'b1, "R5 busy raised", int'(busy_o), 1);
    rd(1'b0, 8'h00, "R10 read refused");
    wr(8'h02, 1'b0, "R10 write refused");
    ticks(WR_MS - 1);
    @(negedge clk);
    check(busy_o == 1'b1, "R5 busy before last tick", int'(busy_o), 1);
    check(wd_period_o == 2'b11, "R5 period held", int'(wd_period_o), 3);
    ticks(1);
    check(busy_o == 1'b0, "R5 busy after last tick", int'(busy_o), 0);
    check(wd_period_o == 2'b01, "R5 period updated", int'(wd_period_o), 1);
    rd(1'b1, 8'h22, "R5 image after commit");

    wr(8'h06, 1'b1, "R8 step two");
    rd(1'b1, 8'h26, "R8 read between steps");
    wr(8'h02, 1'b1, "R8 commit zero");
    ticks(WR_MS);
    check(wd_period_o == 2'b00, "R8 period cleared", int'(wd_period_o), 0);

    wr(8'h06, 1'b1, "R7 arm");
    wp_i = 1'b1;
    wr(8'h62, 1'b0, "R7 protected no ack");
    wp_i = 1'b0;
    check(busy_o == 1'b0, "R7 no commit", int'(busy_o), 0);
    rd(1'b1, 8'h02, "R7 rwel cleared wel kept");

    wr(8'h00, 1'b1, "R9 clear wel");
    rd(1'b1, 8'h00, "R9 image");
    wr(8'h06, 1'b0, "R9 R3 locked again");

    wr(8'h02, 1'b1, "R11 step one");
    wr(8'h06, 1'b1, "R11 step two");
    wr(8'h62, 1'b1, "R11 commit start");
    ticks(3);
    sup_rst_i = 1'b1;
    wr(8'h02, 1'b0, "R11 request during abort");
    check(busy_o == 1'b0, "R11 busy dropped", int'(busy_o), 0);
    sup_rst_i = 1'b0;
    ticks(WR_MS);
    check(wd_period_o == 2'b00, "R11 period kept", int'(wd_period_o), 0);
    rd(1'b1, 8'h02, "R11 image after abort");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R13 all responses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule